// File: doc/BRIEF.md
# Read-Modify-Write Front End for a Replicated Two-Writer Memory

This block sits in front of one write port of a memory that gives two independent writers their own copies of the data. Each address therefore lives in two banks: the "own" bank, which only this port writes, and the "other" bank, which only the second writer writes. Each stored word carries one steering bit above its value field. The writer that most recently wrote an address is found by XOR-ing the steering bits of that address's two copies. Because the steering bit travels inside the data word, no separate steering RAM is needed. Every operation starts by reading both copies of its address. The block then takes the steering bit it needs from the other bank's word and writes the result to the own bank two cycles after the read.

Each cycle the block accepts one operation, either an add of an operand to the stored value or a plain write of the operand. A plain write still issues the read, as a dummy read, so that it can recover the steering bit. The bank read takes one cycle. An operation that follows a recent write to the same address would see stale data, so a two-entry history of this port's last writes supplies the fresh word in that case. The newest matching entry wins.

Top module: `rmw_front`

## Requirements
- R1: While out of reset, `rd_en` equals `op_valid` and `rd_addr` equals `op_addr` in the same cycle. A new operation is accepted every cycle with no stall.
- R2: An operation accepted at a rising edge produces exactly one write (`wr_en` high with `wr_addr` equal to its address) in the cycle after the following rising edge, which is two cycles after its read was issued. An idle cycle produces no write.
- R3: For `op_kind` = 0 (add), the value written is the current value of the address plus the operand, modulo 2^DATA_W.
- R4: For `op_kind` = 1 (write-only), the value written is the operand. The bank read is still issued for it (`rd_en` high).
- R5: Word layout: bit DATA_W is the steering bit and bits DATA_W-1:0 are the value. The own-bank word is taken as current when the two steering bits XOR to SIDE. Otherwise the other-bank word is current.
- R6: The steering bit written equals the steering bit of the other-bank word returned for that operation, XOR SIDE.
- R7: An operation on the same address as the operation of the previous cycle uses that operation's result rather than the stale bank data.
- R8: An operation on the same address as the operation two cycles earlier uses that result as well. When both of the two previous operations match, the newer one takes priority.
- R9: `rst_n` is asynchronous and active low. While it is low, and for two rising edges after it is released, `rd_en` and `wr_en` stay low and operations are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 1 | 0 = add operand, 1 = write operand |
| op_addr | input | ADDR_W | Target address |
| op_operand | input | DATA_W | Operand |
| rd_en | output | 1 | Read request to both banks |
| rd_addr | output | ADDR_W | Read address |
| rd_own_word | input | DATA_W+1 | Own-bank word, one cycle after the request |
| rd_oth_word | input | DATA_W+1 | Other-bank word, one cycle after the request |
| wr_en | output | 1 | Write to the own bank |
| wr_addr | output | ADDR_W | Write address |
| wr_word | output | DATA_W+1 | Word written: steering bit and value |

## Verification
The read request is combinational, so the bench samples `rd_en` and `rd_addr` one time unit after it drives an operation. The write for that operation is registered twice: it is sampled at the second falling edge after the operation was driven. The bench therefore carries each expected write, computed from a reference array at issue time, through a two-deep queue. At each falling edge it compares the queue's oldest entry with the write ports, or expects no write for an idle slot. The second writer's updates and the whole-memory checks of the live value are made only after three idle cycles, once every write in flight has retired.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  // Cycles from read request to write presentation.
  localparam int RD_TO_WR = 2;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_PUT = 1'b1
  } op_kind_e;

  // Own copy is current when the steering bits XOR to the port side.
  function automatic logic own_is_live(input logic own_s, input logic oth_s, input logic side);
    return (own_s ^ oth_s) == side;
  endfunction

endpackage

// File: rtl/rmw_rst_sync.sv
module rmw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run = sync_q[STAGES-1];
endmodule

// File: rtl/rmw_hist.sv
module rmw_hist #(
  parameter int DEPTH  = 2,
  parameter int ADDR_W = 10,
  parameter int WORD_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [WORD_W-1:0] in_word,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic [WORD_W-1:0] hit_word,
  output logic              head_vld,
  output logic [ADDR_W-1:0] head_addr,
  output logic [WORD_W-1:0] head_word
);
  logic [DEPTH-1:0] ent_vld;
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [WORD_W-1:0] ent_word [DEPTH];
  logic [DEPTH-1:0] src_vld;
  logic [ADDR_W-1:0] src_addr [DEPTH];
  logic [WORD_W-1:0] src_word [DEPTH];

  // Entry 0 is the write leaving this cycle; entry i is i cycles older.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == 0) begin : g_head
      assign src_vld[i]  = in_vld;
      assign src_addr[i] = in_addr;
      assign src_word[i] = in_word;
    end else begin : g_tail
      assign src_vld[i]  = ent_vld[i-1];
      assign src_addr[i] = ent_addr[i-1];
      assign src_word[i] = ent_word[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_vld[i] <= 1'b0;
      else        ent_vld[i] <= src_vld[i];
    end

    always_ff @(posedge clk) begin
      if (src_vld[i]) begin
        ent_addr[i] <= src_addr[i];
        ent_word[i] <= src_word[i];
      end
    end
  end

  // Oldest first so that the newest match overrides.
  always_comb begin
    hit      = 1'b0;
    hit_word = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (ent_vld[i] && (ent_addr[i] == look_addr)) begin
        hit      = 1'b1;
        hit_word = ent_word[i];
      end
    end
  end

  assign head_vld  = ent_vld[0];
  assign head_addr = ent_addr[0];
  assign head_word = ent_word[0];
endmodule

// File: rtl/rmw_merge.sv
module rmw_merge
  import rmw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter bit SIDE   = 1'b0
) (
  input  logic [DATA_W:0]   own_word,
  input  logic [DATA_W:0]   oth_word,
  input  logic              byp_hit,
  input  logic [DATA_W:0]   byp_word,
  input  logic              kind,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W:0]   new_word
);
  logic [DATA_W:0]   own_eff;
  logic [DATA_W-1:0] cur_val;
  logic [DATA_W-1:0] nxt_val;
  logic              nxt_steer;

  always_comb begin
    own_eff = byp_hit ? byp_word : own_word;
    if (own_is_live(own_eff[DATA_W], oth_word[DATA_W], SIDE))
      cur_val = own_eff[DATA_W-1:0];
    else
      cur_val = oth_word[DATA_W-1:0];
    if (op_kind_e'(kind) == OP_PUT) nxt_val = operand;
    else                            nxt_val = cur_val + operand;
    nxt_steer = oth_word[DATA_W] ^ SIDE;
    new_word  = {nxt_steer, nxt_val};
  end
endmodule

// File: rtl/rmw_front.sv
module rmw_front
  import rmw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter bit SIDE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_operand,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W:0]   rd_own_word,
  input  logic [DATA_W:0]   rd_oth_word,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W:0]   wr_word
);
  localparam int WORD_W     = DATA_W + 1;
  localparam int HIST_DEPTH = RD_TO_WR;

  logic run;
  logic s1_vld_q, s1_vld_d;
  logic s1_kind_q;
  logic [ADDR_W-1:0] s1_addr_q;
  logic [DATA_W-1:0] s1_opnd_q;
  logic s1_load;
  logic byp_hit;
  logic [WORD_W-1:0] byp_word;
  logic [WORD_W-1:0] new_word;

  rmw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  // Stage 0: issue the read (also the dummy read for write-only).
  assign rd_en   = op_valid & run;
  assign rd_addr = op_addr;

  always_comb begin
    s1_load  = rd_en;
    s1_vld_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld_q <= 1'b0;
    else        s1_vld_q <= s1_vld_d;
  end

  always_ff @(posedge clk) begin
    if (s1_load) begin
      s1_kind_q <= op_kind;
      s1_addr_q <= op_addr;
      s1_opnd_q <= op_operand;
    end
  end

  // Stage 1: bank data arrives; merge with write history.
  rmw_merge #(.DATA_W(DATA_W), .SIDE(SIDE)) u_merge (
    .own_word (rd_own_word),
    .oth_word (rd_oth_word),
    .byp_hit  (byp_hit),
    .byp_word (byp_word),
    .kind     (s1_kind_q),
    .operand  (s1_opnd_q),
    .new_word (new_word)
  );

  // Stage 2: history head is the write register.
  rmw_hist #(.DEPTH(HIST_DEPTH), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (s1_vld_q),
    .in_addr   (s1_addr_q),
    .in_word   (new_word),
    .look_addr (s1_addr_q),
    .hit       (byp_hit),
    .hit_word  (byp_word),
    .head_vld  (wr_en),
    .head_addr (wr_addr),
    .head_word (wr_word)
  );
endmodule

// File: rtl/rmw_front_chk.sv
module rmw_front_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter bit SIDE   = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_kind,
  input logic [DATA_W-1:0] op_operand,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W:0]   rd_oth_word,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W:0]   wr_word
);
  // R9
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!rd_en && !wr_en));

  // R2
  wr_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en == $past(rd_en, 2));

  // R2
  wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr == $past(rd_addr, 2));

  // R4
  put_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(op_kind, 2)) |-> wr_word[DATA_W-1:0] == $past(op_operand, 2));

  // R6
  steer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_word[DATA_W] == ($past(rd_oth_word[DATA_W]) ^ SIDE));

  // R7
  chain_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && wr_addr == $past(wr_addr) && !$past(op_kind, 2))
      |-> wr_word[DATA_W-1:0] ==
          DATA_W'($past(wr_word[DATA_W-1:0]) + $past(op_operand, 2)));
endmodule

bind rmw_front rmw_front_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIDE(SIDE)) u_front_chk (.*);

// File: tb/test_rmw_front.sv
module test_rmw_front;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NA = 1 << AW;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic op_kind = 1'b0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_operand = '0;
  logic rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW:0] rd_own_q = '0;
  logic [DW:0] rd_oth_q = '0;
  logic [DW:0] wr_word;

  logic [DW:0] mem_own [NA];
  logic [DW:0] mem_oth [NA];
  logic [DW-1:0] refm [NA];

  int n_chk = 0;
  int n_fail = 0;

  logic e1_v = 1'b0, e2_v = 1'b0;
  logic [AW-1:0] e1_a, e2_a;
  logic [DW:0] e1_w, e2_w;
  string e1_t, e2_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  rmw_front #(.DATA_W(DW), .ADDR_W(AW), .SIDE(1'b0)) i_rmw_front (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_operand(op_operand), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_own_word(rd_own_q), .rd_oth_word(rd_oth_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word));

  // Bank model: one-cycle read, read-before-write on the same edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) mem_own[i] <= '0;
    end else begin
      if (rd_en) begin
        rd_own_q <= mem_own[rd_addr];
        rd_oth_q <= mem_oth[rd_addr];
      end
      if (wr_en) mem_own[wr_addr] <= wr_word;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic k, input int a, input int x, input string tag);
    logic [DW-1:0] val;
    @(negedge clk);
    if (e2_v)
      chk(wr_en === 1'b1 && wr_addr === e2_a && wr_word === e2_w, e2_t,
          32'({wr_en, wr_addr, wr_word}), 32'({1'b1, e2_a, e2_w}));
    else
      chk(wr_en === 1'b0, "R2 idle", 32'(wr_en), 32'd0);
    e2_v = e1_v; e2_a = e1_a; e2_w = e1_w; e2_t = e1_t;
    e1_v = v;
    if (v) begin
      val = k ? DW'(x) : DW'(refm[a] + DW'(x));
      refm[a] = val;
      e1_a = AW'(a);
      e1_w = {mem_oth[a][DW], val};
      e1_t = tag;
    end
    op_valid = v; op_kind = k; op_addr = AW'(a); op_operand = DW'(x);
    #1;
    chk(rd_en === v && (!v || rd_addr === AW'(a)), k ? "R4 dummy read" : "R1 read issue",
        32'({rd_en, rd_addr}), 32'({v, AW'(a)}));
  endtask

  task automatic drain();
    repeat (3) step(1'b0, 1'b0, 0, 0, "R2");
  endtask

  task automatic oth_put(input int a, input int v);
    @(negedge clk);
    mem_oth[a] = {~mem_own[a][DW], DW'(v)};
    refm[a] = DW'(v);
  endtask

  task automatic live_check();
    logic [DW-1:0] lv;
    @(negedge clk);
    for (int a = 0; a < NA; a++) begin
      lv = ((mem_own[a][DW] ^ mem_oth[a][DW]) == 1'b0) ? mem_own[a][DW-1:0] : mem_oth[a][DW-1:0];
      chk(lv === refm[a], "R5 live value", 32'(lv), 32'(refm[a]));
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=%0d expected<%0d", WD_LIMIT, WD_LIMIT);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NA; i++) begin
      mem_oth[i] = '0;
      refm[i] = '0;
    end
    op_valid = 1'b1;
    repeat (4) @(negedge clk);
    // R9: held in reset with an operation offered
    chk(rd_en === 1'b0 && wr_en === 1'b0, "R9 in reset", 32'({rd_en, wr_en}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_en === 1'b0, "R9 sync release", 32'(rd_en), 32'd0);
    op_valid = 1'b0;
    repeat (3) @(negedge clk);

    // R4: write-only sweep
    for (int a = 0; a < NA; a++) step(1'b1, 1'b1, a, a * 17 + 3, "R4 put");
    drain();
    live_check();

    // R3: adds on distinct addresses, no bypass
    for (int a = 0; a < NA; a++) step(1'b1, 1'b0, a, 200 + a, "R3 add wrap");
    drain();

    // R7: same-address bursts, R8 priority inside them
    for (int a = 0; a < NA; a++) begin
      step(1'b1, 1'b1, a, a * 5, "R7 put");
      step(1'b1, 1'b0, a, 1, "R7 add");
      step(1'b1, 1'b0, a, 2, "R8 newest wins");
      step(1'b1, 1'b1, a, 9, "R8 put in burst");
      step(1'b1, 1'b0, a, 250, "R8 newest wins");
    end
    drain();

    // R8: alternating addresses and gaps
    for (int a = 0; a < NA; a++) begin
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, (i % 2) ? a : (a ^ 1), i + 1, "R8 alternate");
      step(1'b1, 1'b0, a, 7, "R8 gap");
      step(1'b0, 1'b0, 0, 0, "R2");
      step(1'b1, 1'b0, a, 11, "R8 gap");
      step(1'b0, 1'b0, 0, 0, "R2");
      step(1'b0, 1'b0, 0, 0, "R2");
      step(1'b1, 1'b0, a, 13, "R3 memory current");
    end
    drain();
    live_check();

    // R5/R6: other writer takes some addresses
    for (int a = 0; a < NA; a += 2) oth_put(a, 100 + a);
    live_check();
    for (int a = 0; a < NA; a++) step(1'b1, 1'b0, a, 3, "R6 steer");
    for (int a = 0; a < NA; a++) step(1'b1, 1'b0, a, 1, "R5 select");
    drain();
    live_check();
    for (int a = 1; a < NA; a += 2) oth_put(a, 40 + a);
    for (int a = 0; a < NA; a++) step(1'b1, 1'b0, a ^ 1, 6, "R5 select");
    drain();
    live_check();

    // R3: pseudo-random mix with frequent collisions
    lfsr = 16'hACE1;
    for (int n = 0; n < 1200; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[15:12] != 4'd0, lfsr[11] & lfsr[10], int'(lfsr[2:0]), int'(lfsr[9:2]), "R3 random");
      if (n % 150 == 149) begin
        drain();
        oth_put(int'(lfsr[5:3]), int'(lfsr[13:6]));
        live_check();
      end
    end
    drain();
    live_check();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule